// File: doc/BRIEF.md
# Programmable External Memory Bus Controller

This block sits between an internal requester and an external parallel memory bus. It turns each read or write request into a timed sequence of strobes: an address latch enable (ALE) phase, an optional turnaround clock, a read strobe (RS) or write strobe (WS), a second optional turnaround clock, and an optional address-hold clock. It then acknowledges the request. The external space is split into four regions, chosen by a two-bit region select on the request. Each region carries its own control word (enable and bus width) and its own timing word, so that devices with different speeds and widths share one bus.

Configuration arrives through a simple write port. Address 0x0 holds the global enable in bit 0. Addresses 0x4 to 0x7 hold the control words of regions 0 to 3. Addresses 0x8 to 0xB hold the timing words of regions 0 to 3. Writes to any other address have no effect. The internal side uses a request/acknowledge handshake. The requester holds `reqValid` and the request fields steady until it sees `reqAck`, and then drops `reqValid`. Read data is valid on `reqRdData` while `reqAck` is high.

All bus strobes and byte enables are active high. Outside an access, the address, data, strobes, byte enables and the data output enable are all driven to 0.

Top module: `extmem_bus_ctrl`

## Requirements
- R1: The global enable (address 0x0, bit 0) resets to 0. While it is 0, every request gets an error acknowledge and produces no bus activity.
- R2: A request to a region whose control bit 0 is clear gets `reqAck` and `reqErr` together for one cycle, in the cycle after the request is first presented. During that error acknowledge, no strobe, byte enable or data output enable is asserted.
- R3: Each byte cycle starts with `busAle` high for 1 + timing[14:12] clocks.
- R4: On a read, `busRs` stays high for timing[3:0] + 1 clocks in each byte cycle.
- R5: On a write, `busWs` stays high for timing[7:4] + 1 clocks in each byte cycle.
- R6: When timing bit 9 (for reads) or timing bit 8 (for writes) is clear, one clock with no strobe is inserted between ALE and the strobe, and another after the strobe. When the bit is set, neither clock is inserted.
- R7: When timing bit 10 is clear, the address stays driven for one extra clock after the strobe (after any turnaround clock), with no strobe. When bit 10 is set, this clock is left out.
- R8: Control bit 1 set selects a 16-bit region. A wide access there asserts both `busBhe` and `busBle` and uses all 16 data bits. A byte access selects the lane by address bit 0: 0 gives the low lane with `busBle`, and 1 gives the high lane with `busBhe`. Read bytes are returned in `reqRdData[7:0]` with the upper byte 0. Write bytes are driven on both lanes.
- R9: Control bit 1 clear selects an 8-bit region, using data lane [7:0] with only `busBle`.
  - A wide access there becomes two complete byte cycles: the first with address bit 0 at 0 carrying the low byte, the second with address bit 0 at 1 carrying the high byte.
  - Only one acknowledge is given, after the second byte cycle.
- R10: When timing bit 15 is set, `busBhe` and `busBle` stay 0. During a write access, `busAddr[0]` follows `busWs` in every cycle.
- R11: Timing words reset to 0x70FF and control words reset to 0. Timing bit 11 is ignored and changes no timing.
- R12: `reqAck` is a one-cycle pulse in the clock after the last clock of the sequence. The whole access takes, per byte cycle, (1 + ALE waits) + turnaround before + (strobe length) + turnaround after + hold clocks.
- R13: A request takes its region's control and timing words as they stand when the request is accepted. A configuration write in that same cycle affects only later accesses.
- R14: At most one of `busAle`, `busRs`, `busWs` is high at a time. `busDataOe` is high with `busWs` and never with `busRs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration word select |
| cfgWrData | input | 16 | Configuration write data |
| reqValid | input | 1 | Request valid, held until acknowledge |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| reqRegion | input | 2 | Region select |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqWrData | input | 16 | Write data |
| reqAck | output | 1 | One-cycle acknowledge |
| reqErr | output | 1 | Error flag, valid with reqAck |
| reqRdData | output | 16 | Read data, valid with reqAck |
| busAddr | output | ADDR_W | External address |
| busDataOut | output | 16 | External write data |
| busDataOe | output | 1 | External data output enable |
| busDataIn | input | 16 | External read data |
| busAle | output | 1 | Address latch enable |
| busRs | output | 1 | Read strobe |
| busWs | output | 1 | Write strobe |
| busBhe | output | 1 | High byte enable |
| busBle | output | 1 | Low byte enable |

## Verification
A configuration write and the acceptance of a request can land on the same clock edge, and the two contend for the region's timing word. The bench provokes this as follows:
- It sets a 1-clock read strobe on a region.
- On one edge it presents a read to that region together with a write that lengthens the strobe to 16 clocks.
- It measures the strobe of that access and of the next one.

The first must still be one clock long and the second sixteen, which shows that the request captured the word before the write and that the write still took effect.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  localparam int NUM_REGIONS = 4;
  localparam int REGION_W    = $clog2(NUM_REGIONS);
  localparam int CFG_ADDR_W  = 4;

  // configuration word selects
  localparam logic [CFG_ADDR_W-1:0] CFG_GLOBAL      = 4'h0;
  localparam int                    CFG_CTRL_BASE   = 4;
  localparam int                    CFG_TIMING_BASE = 8;

  localparam logic [15:0] TIMING_RESET = 16'h70FF;

  // timing word, bit positions are decoded by the sequencer
  typedef struct packed {
    logic       byteWsMode;  // 15
    logic [2:0] aleWait;     // 14:12
    logic       reserved;    // 11
    logic       noHold;      // 10
    logic       noRdTurn;    // 9
    logic       noWrTurn;    // 8
    logic [3:0] wrLen;       // 7:4
    logic [3:0] rdLen;       // 3:0
  } timingWord_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_TURN_PRE,
    ST_STROBE,
    ST_TURN_POST,
    ST_HOLD,
    ST_ACK,
    ST_ERR
  } busState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic accept;
    logic ale;
    logic rdStrobe;
    logic wrStrobe;
    logic busy;
    logic driveData;
    logic capture;
    logic upperHalf;
  } busCtl_t;

endpackage

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
  import extmem_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqAllowed,
  input  logic        latWrite,
  input  logic        latSplit,
  input  timingWord_t latTiming,
  output busCtl_t     ctl,
  output logic        reqAck,
  output logic        reqErr
);

  busState_e  state, stateNext;
  logic [3:0] cnt, cntNext;
  logic       half, halfNext;

  logic [3:0] strobeLen;
  logic       turnOn, holdOn, aleDone, strobeDone;
  busState_e  endState, postHold, postStrobe;

  logic timingUnused;
  assign timingUnused = ^{latTiming.reserved, latTiming.byteWsMode};

  always_comb begin
    strobeLen  = latWrite ? latTiming.wrLen : latTiming.rdLen;
    turnOn     = latWrite ? !latTiming.noWrTurn : !latTiming.noRdTurn;
    holdOn     = !latTiming.noHold;
    aleDone    = (cnt == {1'b0, latTiming.aleWait});
    strobeDone = (cnt == strobeLen);
    endState   = (latSplit && !half) ? ST_ALE : ST_ACK;
    postHold   = holdOn ? ST_HOLD : endState;
    postStrobe = turnOn ? ST_TURN_POST : postHold;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:      if (reqValid) stateNext = reqAllowed ? ST_ALE : ST_ERR;
      ST_ALE:       if (aleDone) stateNext = turnOn ? ST_TURN_PRE : ST_STROBE;
      ST_TURN_PRE:  stateNext = ST_STROBE;
      ST_STROBE:    if (strobeDone) stateNext = postStrobe;
      ST_TURN_POST: stateNext = postHold;
      ST_HOLD:      stateNext = endState;
      ST_ACK:       stateNext = ST_IDLE;
      ST_ERR:       stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
    cntNext  = (stateNext != state) ? 4'd0 : cnt + 4'd1;
    halfNext = half;
    if (state == ST_IDLE)
      halfNext = 1'b0;
    else if (stateNext == ST_ALE && state != ST_ALE)
      halfNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= 4'd0;
      half  <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      half  <= halfNext;
    end
  end

  always_comb begin
    ctl.accept    = (state == ST_IDLE) && reqValid && reqAllowed;
    ctl.ale       = (state == ST_ALE);
    ctl.rdStrobe  = (state == ST_STROBE) && !latWrite;
    ctl.wrStrobe  = (state == ST_STROBE) && latWrite;
    ctl.busy      = (state == ST_ALE) || (state == ST_TURN_PRE) || (state == ST_STROBE) ||
                    (state == ST_TURN_POST) || (state == ST_HOLD);
    ctl.driveData = ctl.busy && latWrite && (state != ST_ALE);
    ctl.capture   = ctl.rdStrobe && strobeDone;
    ctl.upperHalf = half;
  end

  assign reqAck = (state == ST_ACK) || (state == ST_ERR);
  assign reqErr = (state == ST_ERR);

endmodule

// File: rtl/extmem_datapath.sv
module extmem_datapath
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [15:0]           cfgWrData,
  input  logic [REGION_W-1:0]   reqRegion,
  input  logic                  reqWrite,
  input  logic                  reqWide,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [15:0]           reqWrData,
  input  busCtl_t               ctl,
  output logic                  reqAllowed,
  output logic                  latWrite,
  output logic                  latSplit,
  output timingWord_t           latTiming,
  output logic [15:0]           reqRdData,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [15:0]           busDataOut,
  output logic                  busDataOe,
  input  logic [15:0]           busDataIn,
  output logic                  busBhe,
  output logic                  busBle
);

  logic        globalEn;
  logic        regionEn   [NUM_REGIONS];
  logic        regionBus16[NUM_REGIONS];
  timingWord_t timingReg  [NUM_REGIONS];

  always_ff @(posedge clk) begin
    if (!rstN)
      globalEn <= 1'b0;
    else if (cfgWrEn && cfgAddr == CFG_GLOBAL)
      globalEn <= cfgWrData[0];
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regionEn[r]    <= 1'b0;
        regionBus16[r] <= 1'b0;
        timingReg[r]   <= timingWord_t'(TIMING_RESET);
      end else if (cfgWrEn) begin
        if (cfgAddr == CFG_ADDR_W'(CFG_CTRL_BASE + r)) begin
          regionEn[r]    <= cfgWrData[0];
          regionBus16[r] <= cfgWrData[1];
        end
        if (cfgAddr == CFG_ADDR_W'(CFG_TIMING_BASE + r))
          timingReg[r] <= timingWord_t'(cfgWrData & 16'hF7FF);
      end
    end
  end

  assign reqAllowed = globalEn && regionEn[reqRegion];

  // request snapshot at acceptance
  logic              latBus16, latWideReq;
  logic [ADDR_W-1:0] latAddr;
  logic [15:0]       latData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latWrite   <= 1'b0;
      latBus16   <= 1'b0;
      latWideReq <= 1'b0;
      latAddr    <= '0;
      latData    <= '0;
      latTiming  <= timingWord_t'(TIMING_RESET);
    end else if (ctl.accept) begin
      latWrite   <= reqWrite;
      latBus16   <= regionBus16[reqRegion];
      latWideReq <= reqWide;
      latAddr    <= reqAddr;
      latData    <= reqWrData;
      latTiming  <= timingReg[reqRegion];
    end
  end

  assign latSplit = latWideReq && !latBus16;

  // read capture
  always_ff @(posedge clk) begin
    if (!rstN)
      reqRdData <= '0;
    else if (ctl.accept)
      reqRdData <= '0;
    else if (ctl.capture) begin
      if (latBus16) begin
        if (latWideReq)
          reqRdData <= busDataIn;
        else
          reqRdData <= {8'h00, latAddr[0] ? busDataIn[15:8] : busDataIn[7:0]};
      end else if (ctl.upperHalf)
        reqRdData[15:8] <= busDataIn[7:0];
      else
        reqRdData[7:0] <= busDataIn[7:0];
    end
  end

  // bus drive
  logic addrLow;
  always_comb begin
    addrLow = latSplit ? ctl.upperHalf : latAddr[0];
    if (latTiming.byteWsMode && latWrite)
      addrLow = ctl.wrStrobe;
    busAddr = ctl.busy ? {latAddr[ADDR_W-1:1], addrLow} : '0;

    busBhe = 1'b0;
    busBle = 1'b0;
    if (ctl.busy && !latTiming.byteWsMode) begin
      if (!latBus16)
        busBle = 1'b1;
      else if (latWideReq) begin
        busBhe = 1'b1;
        busBle = 1'b1;
      end else begin
        busBhe = latAddr[0];
        busBle = !latAddr[0];
      end
    end

    busDataOut = '0;
    if (ctl.driveData) begin
      if (latBus16)
        busDataOut = latWideReq ? latData : {latData[7:0], latData[7:0]};
      else
        busDataOut = {8'h00, ctl.upperHalf ? latData[15:8] : latData[7:0]};
    end
    busDataOe = ctl.driveData;
  end

  logic ctlUnused;
  assign ctlUnused = ^{ctl.ale, ctl.rdStrobe};

endmodule

// File: rtl/extmem_bus_ctrl.sv
module extmem_bus_ctrl
  import extmem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWrEn,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [15:0]           cfgWrData,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic                  reqWide,
  input  logic [REGION_W-1:0]   reqRegion,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [15:0]           reqWrData,
  output logic                  reqAck,
  output logic                  reqErr,
  output logic [15:0]           reqRdData,
  output logic [ADDR_W-1:0]     busAddr,
  output logic [15:0]           busDataOut,
  output logic                  busDataOe,
  input  logic [15:0]           busDataIn,
  output logic                  busAle,
  output logic                  busRs,
  output logic                  busWs,
  output logic                  busBhe,
  output logic                  busBle
);

  busCtl_t     ctl;
  logic        reqAllowed, latWrite, latSplit;
  timingWord_t latTiming;

  extmem_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqAllowed(reqAllowed),
    .latWrite  (latWrite),
    .latSplit  (latSplit),
    .latTiming (latTiming),
    .ctl       (ctl),
    .reqAck    (reqAck),
    .reqErr    (reqErr)
  );

  extmem_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .reqRegion (reqRegion),
    .reqWrite  (reqWrite),
    .reqWide   (reqWide),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .ctl       (ctl),
    .reqAllowed(reqAllowed),
    .latWrite  (latWrite),
    .latSplit  (latSplit),
    .latTiming (latTiming),
    .reqRdData (reqRdData),
    .busAddr   (busAddr),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .busDataIn (busDataIn),
    .busBhe    (busBhe),
    .busBle    (busBle)
  );

  assign busAle = ctl.ale;
  assign busRs  = ctl.rdStrobe;
  assign busWs  = ctl.wrStrobe;

endmodule

// File: rtl/extmem_bus_ctrl_chk.sv
module extmem_bus_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic reqAck,
  input logic reqErr,
  input logic busAle,
  input logic busRs,
  input logic busWs,
  input logic busBhe,
  input logic busBle,
  input logic busDataOe,
  input logic busAddr0
);

  assert_strobe_excl_R14: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busAle, busRs, busWs}));

  assert_oe_write_R14: assert property (@(posedge clk) disable iff (!rstN)
    busWs |-> busDataOe);

  assert_oe_read_R14: assert property (@(posedge clk) disable iff (!rstN)
    busRs |-> !busDataOe);

  assert_err_with_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> reqAck);

  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> !(busAle || busRs || busWs || busBhe || busBle || busDataOe));

  assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  assert_ws_select_R10: assert property (@(posedge clk) disable iff (!rstN)
    busWs |-> (busAddr0 || busBhe || busBle));

endmodule

bind extmem_bus_ctrl extmem_bus_ctrl_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqAck   (reqAck),
  .reqErr   (reqErr),
  .busAle   (busAle),
  .busRs    (busRs),
  .busWs    (busWs),
  .busBhe   (busBhe),
  .busBle   (busBle),
  .busDataOe(busDataOe),
  .busAddr0 (busAddr[0])
);

// File: tb/extmem_bus_ctrl_tb.sv
module extmem_bus_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;

  typedef struct packed {
    logic [1:0]  ctrl;
    logic [15:0] timing;
    logic        write;
    logic        wide;
    logic [15:0] addr;
    logic [15:0] wdata;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'b11, 16'h70FF, 1'b0, 1'b1, 16'h1234, 16'h0000},
    '{2'b11, 16'h0700, 1'b1, 1'b1, 16'h0042, 16'hBEEF},
    '{2'b01, 16'h1432, 1'b0, 1'b1, 16'h0080, 16'h0000},
    '{2'b01, 16'h2611, 1'b1, 1'b1, 16'h0100, 16'hA55A},
    '{2'b11, 16'h0300, 1'b0, 1'b0, 16'h0031, 16'h0000},
    '{2'b11, 16'h0B21, 1'b1, 1'b0, 16'h0030, 16'h0077},
    '{2'b11, 16'h8704, 1'b1, 1'b1, 16'h0200, 16'h1357},
    '{2'b00, 16'h0000, 1'b0, 1'b1, 16'h0010, 16'h0000},
    '{2'b01, 16'h0000, 1'b0, 1'b0, 16'h0055, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [1:0] reqRegion = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWrData = '0;
  logic reqAck, reqErr;
  logic [15:0] reqRdData;
  logic [ADDR_W-1:0] busAddr;
  logic [15:0] busDataOut, busDataIn;
  logic busDataOe, busAle, busRs, busWs, busBhe, busBle;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memWord(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] ^ 8'h5A};
  endfunction

  assign busDataIn = memWord(busAddr);

  extmem_bus_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqWide(reqWide), .reqRegion(reqRegion),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqAck(reqAck), .reqErr(reqErr),
    .reqRdData(reqRdData), .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busAle(busAle), .busRs(busRs), .busWs(busWs),
    .busBhe(busBhe), .busBle(busBle)
  );

  int tests = 0;
  int fails = 0;
  logic finished = 1'b0;

  // observations of one access
  int obsTotal, obsAle, obsStrobe, obsPre, obsPost, obsMismatch, obsLanes, nStrobes;
  logic obsErr;
  logic [15:0] obsRd;
  logic [15:0] wsData [2];
  logic        addr0At [2];
  logic        bheAt, bleAt;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doAccess(input logic [1:0] region, input logic wr, input logic wide,
                          input logic [15:0] addr, input logic [15:0] wd,
                          input logic cfgToo, input logic [3:0] cA, input logic [15:0] cD);
    logic afterAle, afterStrobe, prevStrobe;
    obsTotal = 0; obsAle = 0; obsStrobe = 0; obsPre = 0; obsPost = 0;
    obsMismatch = 0; obsLanes = 0; nStrobes = 0; obsErr = 1'b0; obsRd = '0;
    wsData[0] = '0; wsData[1] = '0; addr0At[0] = 1'b0; addr0At[1] = 1'b0;
    bheAt = 1'b0; bleAt = 1'b0;
    afterAle = 1'b0; afterStrobe = 1'b0; prevStrobe = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWide = wide; reqRegion = region;
    reqAddr = addr; reqWrData = wd;
    if (cfgToo) begin
      cfgWrEn = 1'b1; cfgAddr = cA; cfgWrData = cD;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      if (reqAck) begin
        obsErr = reqErr;
        obsRd = reqRdData;
        reqValid = 1'b0;
        break;
      end
      obsTotal++;
      if (busAddr[0] != busWs) obsMismatch++;
      if (busBhe || busBle) obsLanes++;
      if (busAle) begin
        obsAle++; afterAle = 1'b1; afterStrobe = 1'b0; prevStrobe = 1'b0;
      end else if (busRs || busWs) begin
        obsStrobe++;
        if (!prevStrobe && nStrobes < 2) begin
          addr0At[nStrobes] = busAddr[0];
          wsData[nStrobes] = busDataOut;
          if (nStrobes == 0) begin bheAt = busBhe; bleAt = busBle; end
          nStrobes++;
        end
        prevStrobe = 1'b1; afterStrobe = 1'b1;
      end else begin
        prevStrobe = 1'b0;
        if (afterStrobe) obsPost++;
        else if (afterAle) obsPre++;
      end
      if (i == 199) begin
        fails++; tests++;
        $display("FAIL R12 no acknowledge actual=0 expected=1");
        reqValid = 1'b0;
      end
    end
  endtask

  task automatic runVector(input vec_t v, input logic [1:0] region);
    int bytes, aleW, len, turn, hold, perByte;
    logic bus16, mode;
    logic [15:0] f0, f1, expRd, expWs;
    bus16 = v.ctrl[1];
    mode  = v.timing[15];
    bytes = (!bus16 && v.wide) ? 2 : 1;
    aleW  = int'(v.timing[14:12]);
    len   = v.write ? int'(v.timing[7:4]) : int'(v.timing[3:0]);
    turn  = v.write ? int'(!v.timing[8]) : int'(!v.timing[9]);
    hold  = int'(!v.timing[10]);
    perByte = 1 + aleW + turn + len + 1 + turn + hold;
    cfgWrite(4'(4 + region), {14'h0, v.ctrl});
    cfgWrite(4'(8 + region), v.timing);
    doAccess(region, v.write, v.wide, v.addr, v.wdata, 1'b0, 4'h0, 16'h0);
    if (!v.ctrl[0]) begin
      check("R2 error flag on disabled region", int'(obsErr), 1);
      check("R2 no bus cycles on disabled region", obsTotal, 0);
      return;
    end
    check("R2 no error on enabled region", int'(obsErr), 0);
    check("R12 cycles before acknowledge", obsTotal, bytes * perByte);
    check("R3 ALE clocks", obsAle, bytes * (1 + aleW));
    check(v.write ? "R5 write strobe clocks" : "R4 read strobe clocks", obsStrobe, bytes * (len + 1));
    check("R6 turnaround before strobe", obsPre, bytes * turn);
    check("R7 clocks after strobe (turnaround plus hold)", obsPost, bytes * (turn + hold));
    // byte lanes
    if (mode)
      check("R10 byte enables off in byte-write mode", obsLanes, 0);
    else if (!bus16)
      check("R9 8-bit lanes", int'({bheAt, bleAt}), 1);
    else if (v.wide)
      check("R8 16-bit wide lanes", int'({bheAt, bleAt}), 3);
    else
      check("R8 16-bit byte lane", int'({bheAt, bleAt}), v.addr[0] ? 2 : 1);
    // address bit 0 at strobes
    if (mode && v.write) begin
      check("R10 A0 follows WS", obsMismatch, 0);
    end else begin
      for (int k = 0; k < bytes; k++)
        check(bytes == 2 ? "R9 A0 per byte cycle" : "R8 A0 at strobe",
              int'(addr0At[k]), bytes == 2 ? k : int'(v.addr[0]));
    end
    // data
    if (!v.write) begin
      f0 = memWord(v.addr & 16'hFFFE);
      f1 = memWord(v.addr | 16'h0001);
      if (bus16 && v.wide)      expRd = memWord(v.addr);
      else if (bus16)           expRd = {8'h00, v.addr[0] ? memWord(v.addr) >> 8 : memWord(v.addr) & 16'h00FF} & 16'h00FF;
      else if (v.wide)          expRd = {f1[7:0], f0[7:0]};
      else                      expRd = {8'h00, memWord(v.addr) & 16'h00FF} & 16'h00FF;
      check(bus16 ? "R8 read data" : "R9 read data", int'(obsRd), int'(expRd));
    end else begin
      for (int k = 0; k < bytes; k++) begin
        if (bus16 && v.wide) expWs = v.wdata;
        else if (bus16)      expWs = {v.wdata[7:0], v.wdata[7:0]};
        else                 expWs = {8'h00, (k == 1) ? v.wdata[15:8] : v.wdata[7:0]};
        check(bus16 ? "R8 write data" : "R9 write data per byte cycle", int'(wsData[k]), int'(expWs));
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R11 / R1)
    check("R11 reset: no acknowledge", int'(reqAck), 0);
    check("R11 reset: bus quiet", int'({busAle, busRs, busWs, busBhe, busBle, busDataOe}), 0);
    check("R11 reset: address 0", int'(busAddr), 0);

    // global enable off (R1)
    cfgWrite(4'h4, 16'h0003);
    doAccess(2'd0, 1'b0, 1'b1, 16'h0020, 16'h0, 1'b0, 4'h0, 16'h0);
    check("R1 error while global enable is 0", int'(obsErr), 1);
    check("R1 no bus cycles while global enable is 0", obsTotal, 0);

    cfgWrite(4'h0, 16'h0001);
    // default timing 0x70FF on region 2 (R11)
    cfgWrite(4'h6, 16'h0003);
    doAccess(2'd2, 1'b0, 1'b1, 16'h0044, 16'h0, 1'b0, 4'h0, 16'h0);
    check("R11 default timing total clocks", obsTotal, 27);
    check("R11 default read strobe", obsStrobe, 16);
    check("R11 default ALE clocks", obsAle, 8);
    check("R8 default read data", int'(obsRd), int'(memWord(16'h0044)));

    for (int i = 0; i < NVEC; i++)
      runVector(VECS[i], 2'(i % 4));

    // same-cycle configuration write and acceptance (R13)
    cfgWrite(4'h5, 16'h0003);
    cfgWrite(4'h9, 16'h0700);
    doAccess(2'd1, 1'b0, 1'b1, 16'h0060, 16'h0, 1'b1, 4'h9, 16'h070F);
    check("R13 old strobe length used", obsStrobe, 1);
    check("R13 old timing total", obsTotal, 2);
    doAccess(2'd1, 1'b0, 1'b1, 16'h0060, 16'h0, 1'b0, 4'h0, 16'h0);
    check("R13 new strobe length on next access", obsStrobe, 16);

    // global enable cleared again (R1)
    cfgWrite(4'h0, 16'h0000);
    doAccess(2'd1, 1'b1, 1'b1, 16'h0060, 16'h1111, 1'b0, 4'h0, 16'h0);
    check("R1 error after global enable cleared", int'(obsErr), 1);
    check("R1 no bus cycles after global enable cleared", obsTotal, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule